// File: doc/BRIEF.md
# Bus UART Register and Interrupt Front-End

This block is the register side of a serial port. A host on a simple peripheral bus reads and writes four 32-bit words in one cycle each, with no wait states. Bytes written to the data word queue in a transmit FIFO, which a transmitter core drains through a valid/ready byte handshake. Bytes delivered by a receiver core, together with their error strobes, queue in a receive FIFO, and reading the data word pops them.

The status word packs the FIFO fill counts into its top bits, next to level flags and sticky error flags. One interrupt line combines four sources:
- a receive-data request;
- a one-cycle pulse when the transmit FIFO drains to empty;
- a transmit-level request;
- a receive-level request.

The serial bit engines are outside the block. They take the parity, flow-control, loopback and divisor settings from dedicated outputs.

Top module: `uart_regfront`

## Requirements
- R1: After reset, control reads 0x80000000, scaler reads 0, status reads 0x00000006 with the transmitter core idle, and irq_o and tx_valid_o are low.
- R2: Control word (byte offset 0x08) bit map:
  - bits 0, 1, 2, 3, 4, 5, 6, 7, 9 and 10 are writable and read back. They are receiver enable, transmitter enable, receive interrupt enable, transmit-drain interrupt enable, odd parity, parity enable, flow control, loopback, transmit-level interrupt enable and receive-level interrupt enable.
  - bit 31 always reads 1 and ignores writes.
  - all other bits read 0.
  - bits 5, 4, 6 and 7 drive par_en_o, par_odd_o, flow_en_o and loop_en_o.
- R3: The scaler word (offset 0x0C) keeps bits 11:0 of a write, reads them back with the upper bits zero, and drives scaler_o.
- R4: A write to the data word (offset 0x00) appends bits 7:0 to the transmit FIFO. tx_valid_o is high only while the transmitter is enabled and the FIFO is not empty. tx_byte_o shows the oldest byte, and it is removed on a cycle with tx_valid_o and tx_ready_i both high.
- R5: A data write to a transmit FIFO holding DEPTH (8) bytes, with no removal in the same cycle, is discarded.
- R6: While the receiver is disabled, rx_valid_i and the error strobes are ignored.
- R7: A data read returns the oldest received byte in bits 7:0 and removes it. A data read of an empty receive FIFO returns 0 and changes nothing.
- R8: Status word (offset 0x04) bit map:
  - bit 0: receive FIFO not empty.
  - bit 1: transmit FIFO empty and tx_idle_i high.
  - bit 2: transmit FIFO empty.
  - bit 7: transmit count at least DEPTH/2.
  - bit 8: receive count at least DEPTH/2.
  - bit 9: transmit FIFO full.
  - bit 10: receive FIFO full.
  - bits 25:20: transmit count.
  - bits 31:26: receive count.
  - bits 19:11: zero.
- R9: Status bits 3 (break), 5 (parity) and 6 (framing) are set by the matching strobe on an accepted rx_valid_i. Bit 4 (overrun) is set when a byte arrives at a full receive FIFO that is not read in the same cycle; that byte is lost. All four flags stay set until any write to the status word. A flag raised in the same cycle as that write stays set.
- R10: irq_o is high whenever receive interrupt enable is set and the receive FIFO is not empty.
- R11: With transmit-drain interrupt enable set, irq_o pulses for exactly one cycle, the cycle after the transmit FIFO count falls from non-zero to zero.
- R12: irq_o is high while transmit-level enable is set and the transmit count is at most DEPTH/2, and while receive-level enable is set and the receive count is at least DEPTH/2.
- R13: A byte arriving in the same cycle as a data read of a full receive FIFO is stored, with no overrun, and the read returns the previous oldest byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Combined interrupt request |
| tx_valid_o | output | 1 | Byte offered to the transmitter core |
| tx_byte_o | output | 8 | Offered byte |
| tx_ready_i | input | 1 | Transmitter core takes the byte |
| tx_idle_i | input | 1 | Transmitter shifter is empty |
| rx_valid_i | input | 1 | Receiver core delivers a byte |
| rx_byte_i | input | 8 | Delivered byte |
| rx_par_err_i | input | 1 | Parity error on this byte |
| rx_frm_err_i | input | 1 | Framing error on this byte |
| rx_brk_i | input | 1 | Break detected with this byte |
| par_en_o | output | 1 | Parity enable setting |
| par_odd_o | output | 1 | Odd parity setting |
| flow_en_o | output | 1 | Flow-control setting |
| loop_en_o | output | 1 | Loopback setting |
| scaler_o | output | SCALER_W | Baud divisor reload value |

## Verification
Two pairs of events can land in the same cycle, and each pair is forced by driving its two sources on the same clock edge.

The first pair is an incoming byte and a host read of the data word while the receive FIFO is full. The bench fills the FIFO to eight and then raises rx_valid_i in the same cycle as the read. The read data must be the old head, the count must stay at eight, the overrun flag must stay clear, and the new byte must come out last.

The second pair is a framing-error strobe and a host write that clears the error flags. The bench drives the strobe in the cycle of the status write and expects the framing flag to remain set afterwards.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

   localparam logic [1:0] IDX_DATA = 2'd0;
   localparam logic [1:0] IDX_STAT = 2'd1;
   localparam logic [1:0] IDX_CTRL = 2'd2;
   localparam logic [1:0] IDX_SCAL = 2'd3;

   localparam int unsigned PRESENT_BIT = 31;
   localparam int unsigned CNT_FIELD_W = 6;

   typedef struct packed {
      logic rxf_ie;
      logic txf_ie;
      logic loop_en;
      logic flow_en;
      logic par_en;
      logic par_odd;
      logic tx_ie;
      logic rx_ie;
      logic tx_en;
      logic rx_en;
   } ctrl_t;

   function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
      ctrl_t c;
      c.rx_en   = w[0];
      c.tx_en   = w[1];
      c.rx_ie   = w[2];
      c.tx_ie   = w[3];
      c.par_odd = w[4];
      c.par_en  = w[5];
      c.flow_en = w[6];
      c.loop_en = w[7];
      c.txf_ie  = w[9];
      c.rxf_ie  = w[10];
      return c;
   endfunction

   function automatic logic [31:0] ctrl_pack(input ctrl_t c);
      logic [31:0] w;
      w      = '0;
      w[0]   = c.rx_en;
      w[1]   = c.tx_en;
      w[2]   = c.rx_ie;
      w[3]   = c.tx_ie;
      w[4]   = c.par_odd;
      w[5]   = c.par_en;
      w[6]   = c.flow_en;
      w[7]   = c.loop_en;
      w[9]   = c.txf_ie;
      w[10]  = c.rxf_ie;
      return w;
   endfunction

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [WIDTH-1:0]               din,
   input  logic                           pop,
   output logic [WIDTH-1:0]               dout,
   output logic [$clog2(DEPTH+1)-1:0]     count,
   output logic                           full,
   output logic                           empty
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH+1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);

   // pointer wrap: free on a power of two, explicit compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   assign dout  = mem[rd_ptr];
   assign count = cnt_q;

endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_ie,
   input  logic             tx_ie,
   input  logic             txf_ie,
   input  logic             rxf_ie,
   input  logic [CNT_W-1:0] tx_cnt,
   input  logic [CNT_W-1:0] rx_cnt,
   output logic             irq
);
   localparam int unsigned HALF = DEPTH / 2;

   logic tx_busy_q;
   logic tx_drained;

   always_ff @(posedge clk) begin
      if (!rst_n) tx_busy_q <= 1'b0;
      else        tx_busy_q <= (tx_cnt != '0);
   end

   assign tx_drained = tx_busy_q & (tx_cnt == '0);

   assign irq = (rx_ie  & (rx_cnt != '0))
              | (tx_ie  & tx_drained)
              | (txf_ie & (tx_cnt <= CNT_W'(HALF)))
              | (rxf_ie & (rx_cnt >= CNT_W'(HALF)));

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import uart_regfront_pkg::*;
#(
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned SCALER_W = 12,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                irq_o,
   output logic                tx_valid_o,
   output logic [7:0]          tx_byte_o,
   input  logic                tx_ready_i,
   input  logic                tx_idle_i,
   input  logic                rx_valid_i,
   input  logic [7:0]          rx_byte_i,
   input  logic                rx_par_err_i,
   input  logic                rx_frm_err_i,
   input  logic                rx_brk_i,
   output logic                par_en_o,
   output logic                par_odd_o,
   output logic                flow_en_o,
   output logic                loop_en_o,
   output logic [SCALER_W-1:0] scaler_o
);
   localparam int unsigned CNT_W = $clog2(DEPTH+1);
   localparam int unsigned HALF  = DEPTH / 2;

   if (DEPTH < 2 || DEPTH > 63) begin : g_bad_depth
      $error("uart_regfront: DEPTH must lie in 2..63 to fit the count fields");
   end
   if (SCALER_W < 1 || SCALER_W > 20) begin : g_bad_scaler
      $error("uart_regfront: SCALER_W must lie in 1..20");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("uart_regfront: ADDR_W must be at least 4");
   end

   ctrl_t               ctrl_q;
   logic [SCALER_W-1:0] scaler_q;
   logic [3:0]          err_q;      // {framing, parity, overrun, break}
   logic [3:0]          err_set;

   logic [1:0]       idx;
   logic             rd_fire, wr_fire, stat_wr;
   logic             tx_push, tx_pop, rx_take, rx_pop;
   logic [7:0]       tx_head, rx_head;
   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   logic             tx_full, tx_empty, rx_full, rx_empty;
   logic [31:0]      stat_w;
   logic             unused_bits;

   assign idx     = bus_addr[3:2];
   assign rd_fire = bus_sel & ~bus_wr;
   assign wr_fire = bus_sel &  bus_wr;
   assign stat_wr = wr_fire & (idx == IDX_STAT);
   assign tx_push = wr_fire & (idx == IDX_DATA);
   assign rx_pop  = rd_fire & (idx == IDX_DATA);
   assign rx_take = rx_valid_i & ctrl_q.rx_en;
   assign tx_valid_o = ctrl_q.tx_en & ~tx_empty;
   assign tx_pop     = tx_valid_o & tx_ready_i;
   assign tx_byte_o  = tx_head;
   assign unused_bits = ^{bus_addr, bus_wdata};

   uart_rf_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[7:0]),
      .pop(tx_pop), .dout(tx_head), .count(tx_cnt),
      .full(tx_full), .empty(tx_empty)
   );

   uart_rf_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_take), .din(rx_byte_i),
      .pop(rx_pop), .dout(rx_head), .count(rx_cnt),
      .full(rx_full), .empty(rx_empty)
   );

   uart_rf_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .rx_ie(ctrl_q.rx_ie), .tx_ie(ctrl_q.tx_ie),
      .txf_ie(ctrl_q.txf_ie), .rxf_ie(ctrl_q.rxf_ie),
      .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .irq(irq_o)
   );

   assign err_set = {rx_take & rx_frm_err_i,
                     rx_take & rx_par_err_i,
                     rx_take & rx_full & ~rx_pop,
                     rx_take & rx_brk_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         scaler_q <= '0;
         err_q    <= '0;
      end else begin
         if (wr_fire && idx == IDX_CTRL) ctrl_q   <= ctrl_unpack(bus_wdata);
         if (wr_fire && idx == IDX_SCAL) scaler_q <= bus_wdata[SCALER_W-1:0];
         err_q <= (stat_wr ? 4'b0 : err_q) | err_set;
      end
   end

   always_comb begin
      stat_w        = '0;
      stat_w[0]     = ~rx_empty;
      stat_w[1]     = tx_empty & tx_idle_i;
      stat_w[2]     = tx_empty;
      stat_w[6:3]   = err_q;
      stat_w[7]     = (tx_cnt >= CNT_W'(HALF));
      stat_w[8]     = (rx_cnt >= CNT_W'(HALF));
      stat_w[9]     = tx_full;
      stat_w[10]    = rx_full;
      stat_w[25:20] = CNT_FIELD_W'(tx_cnt);
      stat_w[31:26] = CNT_FIELD_W'(rx_cnt);
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_fire) begin
         case (idx)
            IDX_DATA: bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
            IDX_STAT: bus_rdata = stat_w;
            IDX_CTRL: bus_rdata = ctrl_pack(ctrl_q) | (32'h1 << PRESENT_BIT);
            default:  bus_rdata[SCALER_W-1:0] = scaler_q;
         endcase
      end
   end

   assign par_en_o  = ctrl_q.par_en;
   assign par_odd_o = ctrl_q.par_odd;
   assign flow_en_o = ctrl_q.flow_en;
   assign loop_en_o = ctrl_q.loop_en;
   assign scaler_o  = scaler_q;

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [1:0]       word_idx,
   input logic [31:0]      bus_rdata,
   input logic             irq,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic             tx_en,
   input logic             tx_ie,
   input logic             rx_en,
   input logic             rx_ie,
   input logic [CNT_W-1:0] tx_cnt,
   input logic [CNT_W-1:0] rx_cnt,
   input logic [3:0]       err
);
   logic data_wr, stat_wr, ctrl_rd;
   assign data_wr = bus_sel & bus_wr & (word_idx == 2'd0);
   assign stat_wr = bus_sel & bus_wr & (word_idx == 2'd1);
   assign ctrl_rd = bus_sel & ~bus_wr & (word_idx == 2'd2);

   assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

   assert_present_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rd |-> bus_rdata[31]);

   assert_tx_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_en && tx_cnt != '0));

   assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && tx_cnt == CNT_W'(DEPTH) && !(tx_valid && tx_ready))
      |=> tx_cnt == CNT_W'(DEPTH));

   assert_rx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> rx_cnt <= $past(rx_cnt));

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> (err & $past(err)) == $past(err));

   assert_rx_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ie && rx_cnt != '0) |-> irq);

   assert_drain_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ie && $past(tx_cnt) != '0 && tx_cnt == '0) |-> irq);

endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .word_idx(bus_addr[3:2]), .bus_rdata(bus_rdata), .irq(irq_o),
   .tx_valid(tx_valid_o), .tx_ready(tx_ready_i),
   .tx_en(ctrl_q.tx_en), .tx_ie(ctrl_q.tx_ie),
   .rx_en(ctrl_q.rx_en), .rx_ie(ctrl_q.rx_ie),
   .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .err(err_q)
);

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;
   localparam int D = 8;
   localparam int H = D / 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, tx_valid_o;
   logic [7:0]  tx_byte_o;
   logic        tx_ready_i = 1'b0, tx_idle_i = 1'b1;
   logic        rx_valid_i = 1'b0;
   logic [7:0]  rx_byte_i = '0;
   logic        rx_par_err_i = 1'b0, rx_frm_err_i = 1'b0, rx_brk_i = 1'b0;
   logic        par_en_o, par_odd_o, flow_en_o, loop_en_o;
   logic [11:0] scaler_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   uart_regfront u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o),
      .tx_ready_i(tx_ready_i), .tx_idle_i(tx_idle_i),
      .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
      .rx_par_err_i(rx_par_err_i), .rx_frm_err_i(rx_frm_err_i),
      .rx_brk_i(rx_brk_i), .par_en_o(par_en_o), .par_odd_o(par_odd_o),
      .flow_en_o(flow_en_o), .loop_en_o(loop_en_o), .scaler_o(scaler_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // flags: {break, framing, parity}
   task automatic rxp(input logic [7:0] b, input logic [2:0] f);
      @(negedge clk);
      rx_valid_i = 1'b1; rx_byte_i = b;
      {rx_brk_i, rx_frm_err_i, rx_par_err_i} = f;
      @(negedge clk);
      rx_valid_i = 1'b0;
      {rx_brk_i, rx_frm_err_i, rx_par_err_i} = 3'b000;
   endtask

   // e: {framing, parity, overrun, break}; tx_idle_i held at 1
   function automatic logic [31:0] exp_stat(input int txc, input int rxc, input logic [3:0] e);
      logic [31:0] s;
      s        = '0;
      s[0]     = (rxc != 0);
      s[1]     = (txc == 0);
      s[2]     = (txc == 0);
      s[6:3]   = e;
      s[7]     = (txc >= H);
      s[8]     = (rxc >= H);
      s[9]     = (txc == D);
      s[10]    = (rxc == D);
      s[25:20] = 6'(txc);
      s[31:26] = 6'(rxc);
      return s;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      brd(4'h4, v); chk("R1 status", v, 32'h6);
      brd(4'h8, v); chk("R1 ctrl", v, 32'h8000_0000);
      brd(4'hC, v); chk("R1 scaler", v, 32'h0);
      chk("R1 irq/txv", {30'b0, irq_o, tx_valid_o}, 32'h0);

      // R2 control map
      bwr(4'h8, 32'hFFFF_FFFF);
      brd(4'h8, v); chk("R2 ctrl all ones", v, 32'h8000_06FF);
      chk("R2 cfg outputs", {28'b0, par_en_o, par_odd_o, flow_en_o, loop_en_o}, 32'hF);
      bwr(4'h8, 32'h0);
      brd(4'h8, v); chk("R2 ctrl cleared", v, 32'h8000_0000);

      // R3 scaler
      bwr(4'hC, 32'hFFFF_A5C3);
      brd(4'hC, v); chk("R3 scaler read", v, 32'h5C3);
      chk("R3 scaler_o", {20'b0, scaler_o}, 32'h5C3);

      // R4/R5/R8/R12 transmit fill sweep, transmitter disabled, level irq on
      bwr(4'h8, 32'h200);
      for (int k = 1; k <= D + 2; k++) begin
         bwr(4'h0, 32'h10 + k);
         c = (k < D) ? k : D;
         brd(4'h4, v); chk("R8 R5 tx fill status", v, exp_stat(c, 0, 4'b0));
         chk("R12 tx level irq", {31'b0, irq_o}, {31'b0, (c <= H)});
         chk("R4 no offer while disabled", {31'b0, tx_valid_o}, 32'h0);
      end

      // R4/R5 drain in order; the two extra bytes were dropped
      bwr(4'h8, 32'h2);
      for (int i = 0; i < D; i++) begin
         chk("R4 offer valid", {31'b0, tx_valid_o}, 32'h1);
         chk("R4 order", {24'b0, tx_byte_o}, 32'h11 + i);
         tx_ready_i = 1'b1;
         @(negedge clk);
         tx_ready_i = 1'b0;
      end
      chk("R5 dropped bytes absent", {31'b0, tx_valid_o}, 32'h0);
      brd(4'h4, v); chk("R8 tx empty again", v, exp_stat(0, 0, 4'b0));

      // R8/R9/R12 receive fill sweep incl. overrun
      bwr(4'h8, 32'h401);
      for (int k = 1; k <= D + 1; k++) begin
         rxp(8'h40 + 8'(k), 3'b000);
         c = (k < D) ? k : D;
         brd(4'h4, v);
         chk("R8 R9 rx fill status", v, exp_stat(0, c, {2'b00, (k > D), 1'b0}));
         chk("R12 rx level irq", {31'b0, irq_o}, {31'b0, (c >= H)});
      end

      // R7/R10 drain by reads
      bwr(4'h8, 32'h5);
      chk("R10 irq with data", {31'b0, irq_o}, 32'h1);
      for (int i = 0; i < D; i++) begin
         brd(4'h0, v); chk("R7 rx order", v, 32'h41 + i);
         brd(4'h4, v); chk("R7 R9 count after pop", v, exp_stat(0, D - 1 - i, 4'b0010));
      end
      chk("R10 irq idle when empty", {31'b0, irq_o}, 32'h0);
      brd(4'h0, v); chk("R7 empty read", v, 32'h0);
      brd(4'h4, v); chk("R7 empty read no effect", v, exp_stat(0, 0, 4'b0010));
      bwr(4'h4, 32'h0);
      brd(4'h4, v); chk("R9 clear by write", v, exp_stat(0, 0, 4'b0));

      // R9 sticky errors
      bwr(4'h8, 32'h1);
      rxp(8'h55, 3'b001);
      brd(4'h4, v); chk("R9 parity", v, exp_stat(0, 1, 4'b0100));
      rxp(8'h56, 3'b000);
      brd(4'h4, v); chk("R9 parity sticky", v, exp_stat(0, 2, 4'b0100));
      rxp(8'h57, 3'b110);
      brd(4'h4, v); chk("R9 framing+break", v, exp_stat(0, 3, 4'b1101));
      bwr(4'h4, 32'h0);
      brd(4'h4, v); chk("R9 clear keeps data", v, exp_stat(0, 3, 4'b0));
      // same cycle: framing strobe and status write
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = '0;
      rx_valid_i = 1'b1; rx_byte_i = 8'h58; rx_frm_err_i = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; rx_valid_i = 1'b0; rx_frm_err_i = 1'b0;
      brd(4'h4, v); chk("R9 set beats clear", v, exp_stat(0, 4, 4'b1000));
      for (int i = 0; i < 4; i++) begin
         brd(4'h0, v); chk("R7 error bytes order", v, 32'h55 + i);
      end
      bwr(4'h4, 32'h0);

      // R6 receiver disabled
      bwr(4'h8, 32'h0);
      rxp(8'h99, 3'b111);
      brd(4'h4, v); chk("R6 ignored when disabled", v, exp_stat(0, 0, 4'b0));

      // R13 push and pop together on a full receive FIFO
      bwr(4'h8, 32'h1);
      for (int i = 0; i < D; i++) rxp(8'h60 + 8'(i), 3'b000);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h0;
      rx_valid_i = 1'b1; rx_byte_i = 8'h77;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0; rx_valid_i = 1'b0;
      chk("R13 read old head", v, 32'h60);
      brd(4'h4, v); chk("R13 full no overrun", v, exp_stat(0, D, 4'b0));
      for (int i = 1; i < D; i++) begin
         brd(4'h0, v); chk("R13 order", v, 32'h60 + i);
      end
      brd(4'h0, v); chk("R13 new byte last", v, 32'h77);

      // R11 drain pulse
      bwr(4'h8, 32'hA);
      bwr(4'h0, 32'hC3);
      chk("R11 no irq while queued", {31'b0, irq_o}, 32'h0);
      tx_ready_i = 1'b1;
      @(negedge clk);
      tx_ready_i = 1'b0;
      chk("R11 pulse after drain", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      chk("R11 pulse one cycle", {31'b0, irq_o}, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule